// File: doc/BRIEF.md
# Packed Pixel Format Converter

This block is a SIMD datapath that moves packed pixel data between fixed-point lanes and byte or narrower lanes. A 9-bit operation code selects one of five conversions: a four-lane 16-bit to byte pack, a two-lane 32-bit to byte pack, a two-lane 32-bit to 16-bit saturating pack, a byte to 16-bit expansion, and a byte interleave of two 32-bit words. The three packs take a left-shift amount from a small field of a scale configuration word. Each pack then applies its own right shift and its own clamp range.

The conversion itself is combinational. Its result is captured in an output register, so a request presented with `in_valid` appears one cycle later with `out_valid`. A code outside the five legal ones returns a zero result and raises `illegal`. Register file access, instruction decode beyond the operation code, and fault handling belong to the surrounding pipeline.

Top module: `pixfmt_conv`

## Requirements
- R1: An operation code other than 0x03B, 0x03A, 0x03D, 0x04D or 0x04B yields `result` = 0 with `illegal` = 1. Every legal code yields `illegal` = 0.
- R2: `out_valid` is `in_valid` delayed by one cycle. `result` and `illegal` load only when `in_valid` is high and hold their values otherwise.
- R3: With code 0x03B, each signed 16-bit lane k of `src_b` is shifted left by `scale_cfg[6:3]`, then arithmetically right by 7, then clamped to 0..255. The byte goes to `result[8k+7:8k]`.
- R4: With code 0x03B, `result[63:32]` is zero.
- R5: With code 0x03A, each signed 32-bit lane k of `src_b` is shifted left by `scale_cfg[7:3]`, then arithmetically right by 23, then clamped to 0..255. The byte is placed at `result[32k+7:32k]`.
- R6: With code 0x03A, every byte of `result` other than bytes 0 and 4 equals the next-lower byte of `src_a`, which is `src_a` shifted left by 8.
- R7: With code 0x03D, each signed 32-bit lane k of `src_b` is shifted left by `scale_cfg[7:3]`, then arithmetically right by 16, then saturated to -32768..32767. The value goes to `result[16k+15:16k]`, and `result[63:32]` is zero.
- R8: With code 0x04D, byte k of `src_b[31:0]` appears at `result[16k+11:16k+4]`. All other result bits are zero.
- R9: With code 0x04B, `result[16k+7:16k]` is byte k of `src_b` and `result[16k+15:16k+8]` is byte k of `src_a`, for k = 0..3.
- R10: Left shifts of up to 31 never wrap before the clamp. For example, a 32-bit lane of 1 with scale 31 packs to 255, not 0.
- R11: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 9 | Operation select |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| scale_cfg | input | 32 | Scale configuration word; shift amount taken from bit 3 upward |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered conversion result |
| illegal | output | 1 | Registered flag for an unrecognised code |

## Verification
In the 32-bit pack, a clamped lane byte and the carried, shifted bytes of `src_a` land in the same output word in the same cycle. An error in either one corrupts the other's neighbours. The bench provokes this by pairing `src_a` values with all bytes set against lanes that overflow in both directions and against lanes that stay in range. It then compares the full 64-bit word with a model built from R5 and R6. A second overlap happens when an illegal code arrives right after a legal request: the flag and the zeroed result must switch together, and the idle cycle that follows must leave both unchanged.

// File: rtl/pixfmt_conv.sv
module pixfmt_conv #(
  parameter int SCALE_LSB = 3,
  parameter int WIDE      = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [8:0]  opcode,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [31:0] scale_cfg,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        illegal
);

  localparam logic [8:0] OP_PACK16 = 9'h03B;
  localparam logic [8:0] OP_PACK32 = 9'h03A;
  localparam logic [8:0] OP_PACKFX = 9'h03D;
  localparam logic [8:0] OP_EXPAND = 9'h04D;
  localparam logic [8:0] OP_MERGE  = 9'h04B;
  localparam logic [63:0] P32_HOLE = 64'h0000_00ff_0000_00ff;

  logic [3:0]  sc4;
  logic [4:0]  sc5;
  logic [63:0] nxt;
  logic        bad;
  logic signed [WIDE-1:0] t;

  assign sc4 = scale_cfg[SCALE_LSB +: 4];
  assign sc5 = scale_cfg[SCALE_LSB +: 5];

  function automatic logic [7:0] clamp_u8(input logic signed [WIDE-1:0] v);
    if (v < 0)        return 8'h00;
    else if (v > 255) return 8'hff;
    else              return v[7:0];
  endfunction

  function automatic logic [15:0] sat_s16(input logic signed [WIDE-1:0] v);
    if (v < -32768)     return 16'h8000;
    else if (v > 32767) return 16'h7fff;
    else                return v[15:0];
  endfunction

  always_comb begin
    nxt = '0;
    bad = 1'b0;
    t   = '0;
    case (opcode)
      OP_PACK16:
        for (int k = 0; k < 4; k++) begin
          t = {{(WIDE-16){src_b[16*k+15]}}, src_b[16*k +: 16]};
          t = t <<< sc4;
          t = t >>> 7;
          nxt[8*k +: 8] = clamp_u8(t);
        end
      OP_PACK32: begin
        nxt = (src_a << 8) & ~P32_HOLE;
        for (int k = 0; k < 2; k++) begin
          t = {{(WIDE-32){src_b[32*k+31]}}, src_b[32*k +: 32]};
          t = t <<< sc5;
          t = t >>> 23;
          nxt[32*k +: 8] = clamp_u8(t);
        end
      end
      OP_PACKFX:
        for (int k = 0; k < 2; k++) begin
          t = {{(WIDE-32){src_b[32*k+31]}}, src_b[32*k +: 32]};
          t = t <<< sc5;
          t = t >>> 16;
          nxt[16*k +: 16] = sat_s16(t);
        end
      OP_EXPAND:
        for (int k = 0; k < 4; k++)
          nxt[16*k +: 16] = {4'h0, src_b[8*k +: 8], 4'h0};
      OP_MERGE:
        for (int k = 0; k < 4; k++)
          nxt[16*k +: 16] = {src_a[8*k +: 8], src_b[8*k +: 8]};
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt;
        illegal <= bad;
      end
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == 64'd0));
  assert_pack16_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_PACK16) |=> (result[63:32] == 32'd0));
  assert_packfx_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_PACKFX) |=> (result[63:32] == 32'd0));
  assert_expand_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_EXPAND) |=> ((result & 64'hf00f_f00f_f00f_f00f) == 64'd0));

endmodule

// File: tb/pixfmt_conv_bench.sv
module pixfmt_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [8:0]  opcode;
  logic [63:0] src_a, src_b;
  logic [31:0] scale_cfg;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixfmt_conv u_pixfmt_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .scale_cfg(scale_cfg),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [7:0] ref_u8(longint v);
    return (v < 0) ? 8'h00 : (v > 255) ? 8'hff : v[7:0];
  endfunction

  function automatic logic [15:0] ref_s16(longint v);
    return (v < -32768) ? 16'h8000 : (v > 32767) ? 16'h7fff : v[15:0];
  endfunction

  function automatic logic [64:0] model(logic [8:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [31:0] sc);
    logic [63:0] r = '0;
    longint v;
    int sh4 = int'(sc[6:3]);
    int sh5 = int'(sc[7:3]);
    case (op)
      9'h03B: for (int k = 0; k < 4; k++) begin
        v = {{48{b[16*k+15]}}, b[16*k +: 16]};
        v = (v << sh4) >>> 7;
        r[8*k +: 8] = ref_u8(v);
      end
      9'h03A: begin
        for (int n = 1; n < 8; n++) if (n != 4) r[8*n +: 8] = a[8*(n-1) +: 8];
        for (int k = 0; k < 2; k++) begin
          v = {{32{b[32*k+31]}}, b[32*k +: 32]};
          v = (v << sh5) >>> 23;
          r[32*k +: 8] = ref_u8(v);
        end
      end
      9'h03D: for (int k = 0; k < 2; k++) begin
        v = {{32{b[32*k+31]}}, b[32*k +: 32]};
        v = (v << sh5) >>> 16;
        r[16*k +: 16] = ref_s16(v);
      end
      9'h04D: for (int k = 0; k < 4; k++) r[16*k+4 +: 8] = b[8*k +: 8];
      9'h04B: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]   = b[8*k +: 8];
        r[16*k+8 +: 8] = a[8*k +: 8];
      end
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic check(string req, logic [64:0] got, logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(string req, logic [8:0] op, logic [63:0] a,
                     logic [63:0] b, logic [31:0] sc);
    logic [64:0] e;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b; scale_cfg = sc;
    e = model(op, a, b, sc);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {64'd0, out_valid}, 65'd1);
    check(req, {illegal, result}, e);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] ops [5] = '{9'h03B, 9'h03A, 9'h03D, 9'h04D, 9'h04B};
    logic [64:0] held;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; src_a = '0; src_b = '0; scale_cfg = '0;
    repeat (3) @(negedge clk);
    check("R11 reset", {out_valid, illegal, result[62:0]}, 65'd0);
    check("R11 reset hi", {64'd0, result[63]}, 65'd0);
    rst_n = 1'b1;

    run("R3 clamp hi/lo", 9'h03B, 64'd0, 64'h7fff_8000_0100_0080, 32'd15 << 3);
    run("R3 no scale", 9'h03B, 64'd0, 64'h0100_7fff_ff80_0200, 32'd0);
    run("R4 upper zero", 9'h03B, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0, 32'd3 << 3);
    run("R5 R6 overlap", 9'h03A, 64'hffff_ffff_ffff_ffff, 64'h7fff_ffff_8000_0000, 32'd0);
    run("R5 in range", 9'h03A, 64'h0102_0304_0506_0708, 64'h0000_4000_0040_0000, 32'd0);
    run("R10 no wrap", 9'h03A, 64'd0, 64'h0000_0001_0000_0001, 32'd31 << 3);
    run("R10 no wrap neg", 9'h03D, 64'd0, 64'hffff_ffff_0000_0001, 32'd31 << 3);
    run("R7 saturate", 9'h03D, 64'd0, 64'h8000_0000_7fff_ffff, 32'd0);
    run("R7 scaled", 9'h03D, 64'd0, 64'h0001_2345_fffe_dcba, 32'd4 << 3);
    run("R8 expand", 9'h04D, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_a55a_ff01, 32'd0);
    run("R9 merge", 9'h04B, 64'h0000_0000_a1a2_a3a4, 64'hffff_ffff_b1b2_b3b4, 32'd0);
    run("R1 illegal after legal", 9'h1ff, 64'h1, 64'h2, 32'd0);
    run("R1 legal clears", 9'h04B, 64'h0000_0000_0000_00ff, 64'd0, 32'd0);

    held = {illegal, result};
    @(negedge clk);
    opcode = 9'h000; src_b = 64'hdead_beef_dead_beef;
    @(negedge clk);
    check("R2 idle valid", {64'd0, out_valid}, 65'd0);
    check("R2 idle hold", {illegal, result}, held);

    for (int i = 0; i < 400; i++) begin
      logic [8:0] op;
      logic [63:0] a, b;
      op = ($urandom_range(0, 5) == 5) ? 9'($urandom) : ops[$urandom_range(0, 4)];
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case (op)
        9'h03B:  run("R3 random", op, a, b, $urandom);
        9'h03A:  run("R5 R6 random", op, a, b, $urandom);
        9'h03D:  run("R7 random", op, a, b, $urandom);
        9'h04D:  run("R8 random", op, a, b, $urandom);
        9'h04B:  run("R9 random", op, a, b, $urandom);
        default: run("R1 random", op, a, b, $urandom);
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule